// File: doc/BRIEF.md
# PWM Dead-Band Delay Generator

This block sits after the stage that forms the raw edges of a PWM pair. It turns two raw waveforms, A and B, into a pair of outputs with a guard gap between them. Two delay paths do this. The rising path holds back every rising edge of its source by a programmable count of ticks. The falling path holds back every falling edge of its source in the same way. Each delay is a 10-bit value from 0 to 1023 ticks. A static configuration sets four things: which raw input feeds each path, which outputs come from a delayed path and which pass straight through, whether each delayed path is inverted, and whether the delay counters advance on every fast clock or only on the base-rate tick.

Each path is a three-state machine. `ST_OFF` means the output is inactive. `ST_WAIT` means the source has gone active and the counter is running. `ST_ON` means the output is active. There are five transitions:
- `OFF->WAIT`: the source goes active and the delay is nonzero.
- `OFF->ON`: the source goes active and the delay is zero.
- `WAIT->ON`: the delay count completes.
- `WAIT->OFF`: the source drops before the count completes, so a short pulse is swallowed.
- `ON->OFF`: the source drops.

The falling path runs the same machine on the inverted source and inverts its result. Its reset state is `ST_ON`, which gives an output of 0.

Top module: `pwm_deadband_gen`

## Requirements
- R1: After reset, with both inputs low, both delayed paths present 0 before any polarity inversion. With `path_sel`=3 and `inv_sel`=0, both outputs read 0.
- R2: `src_sel` chooses the path sources. Bit 0 set feeds B to the rising path, otherwise A. Bit 1 set feeds B to the falling path, otherwise A. The values are 0=A/A, 1=rising B and falling A, 2=rising A and falling B, 3=B/B.
- R3: `path_sel` chooses the outputs. Bit 1 set drives `pwm_a_out` from the rising path, otherwise from `pwm_a_in` combinationally. Bit 0 set drives `pwm_b_out` from the falling path, otherwise from `pwm_b_in` combinationally.
- R4: `inv_sel` bit 0 inverts the rising path and bit 1 inverts the falling path. Inversion acts only where that path reaches an output.
- R5: The rising path with delay D>0 goes high at the (D+1)th clock edge that sees its source high, while ticks are enabled. It goes low at the first clock edge that sees the source low.
- R6: The falling path goes high at the first clock edge that sees its source high. With delay D>0 and ticks enabled, it goes low at the (D+1)th clock edge that sees the source low.
- R7: A source high pulse that lasts D or fewer ticks never raises the rising path output.
- R8: A delay of 0 makes a path follow its source one clock edge later.
- R9: With `half_cycle_en`=0, the counter advances only on clocks where `base_tick` is 1. With `half_cycle_en`=1, it advances on every clock and `base_tick` is ignored.
- R10: A delay of 1023 makes the rising output go high at the 1024th clock edge that sees the source high, with `half_cycle_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | Base-rate tick enable |
| half_cycle_en | input | 1 | 1: the counters advance every clock |
| rise_dly | input | 10 | Rising-edge delay in ticks |
| fall_dly | input | 10 | Falling-edge delay in ticks |
| src_sel | input | 2 | Source select for each path |
| path_sel | input | 2 | Output path select |
| inv_sel | input | 2 | Per-path inversion |
| pwm_a_in | input | 1 | Raw PWM A |
| pwm_b_in | input | 1 | Raw PWM B |
| pwm_a_out | output | 1 | Output A |
| pwm_b_out | output | 1 | Output B |

## Verification
Outputs in bypass follow the inputs in the same cycle. A delayed output reflects a change one clock edge after that edge first samples the new source value. When the delay is D and ticks are enabled, a delayed edge appears after D+1 edges.

The bench drives inputs at the falling clock edge and samples 1 ns after a rising edge. Each delay check reads the output after exactly D edges, where the edge must not yet have appeared, and again after D+1 edges, where it must have appeared. The mode table holds each setting for three edges before it checks the steady value.

// File: rtl/pwm_db_pkg.sv
package pwm_db_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_ON   = 2'd2
    } edge_st_t;
endpackage

// File: rtl/db_edge_path.sv
module db_edge_path
    import pwm_db_pkg::*;
#(
    parameter int DLY_W = 10,
    parameter bit RISE  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             src,
    input  logic [DLY_W-1:0] dly,
    output logic             dout
);
    localparam edge_st_t RST_ST = RISE ? ST_OFF : ST_ON;

    edge_st_t         st_q, st_d;
    logic [DLY_W-1:0] cnt_q, cnt_d;
    logic [DLY_W:0]   cnt_inc;
    logic             x;

    // The falling path runs the same machine on the inverted source.
    assign x       = RISE ? src : ~src;
    assign cnt_inc = {1'b0, cnt_q} + 1'b1;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_OFF: begin
                if (x) begin
                    cnt_d = '0;
                    st_d  = (dly == '0) ? ST_ON : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!x) begin
                    st_d = ST_OFF;
                end else if (tick) begin
                    if (cnt_inc >= {1'b0, dly}) st_d = ST_ON;
                    else                        cnt_d = cnt_inc[DLY_W-1:0];
                end
            end
            ST_ON: begin
                if (!x) st_d = ST_OFF;
            end
            default: st_d = RST_ST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= RST_ST;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        dout = (st_q == ST_ON) ^ ~RISE;
    end

    p_drop_follows_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!x) |=> (st_q != ST_ON));

    p_wait_needs_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT) |-> $past(x));

    p_hold_without_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && x && !tick) |=> (st_q == ST_WAIT && $stable(cnt_q)));

    p_on_needs_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q == ST_ON)) |-> $past(x));
endmodule

// File: rtl/pwm_deadband_gen.sv
module pwm_deadband_gen #(
    parameter int DLY_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick,
    input  logic             half_cycle_en,
    input  logic [DLY_W-1:0] rise_dly,
    input  logic [DLY_W-1:0] fall_dly,
    input  logic [1:0]       src_sel,
    input  logic [1:0]       path_sel,
    input  logic [1:0]       inv_sel,
    input  logic             pwm_a_in,
    input  logic             pwm_b_in,
    output logic             pwm_a_out,
    output logic             pwm_b_out
);
    localparam int NPATH = 2;

    logic             cnt_tick;
    logic [NPATH-1:0] path_src;
    logic [NPATH-1:0] path_out;
    logic [NPATH-1:0] path_pol;
    logic [DLY_W-1:0] path_dly [NPATH];

    assign cnt_tick    = half_cycle_en | base_tick;
    // index 0 is the rising path, index 1 the falling path
    assign path_src[0] = src_sel[0] ? pwm_b_in : pwm_a_in;
    assign path_src[1] = src_sel[1] ? pwm_b_in : pwm_a_in;
    assign path_dly[0] = rise_dly;
    assign path_dly[1] = fall_dly;

    for (genvar i = 0; i < NPATH; i++) begin : g_path
        db_edge_path #(
            .DLY_W (DLY_W),
            .RISE  (i == 0)
        ) u_path (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (cnt_tick),
            .src   (path_src[i]),
            .dly   (path_dly[i]),
            .dout  (path_out[i])
        );
        assign path_pol[i] = path_out[i] ^ inv_sel[i];
    end

    assign pwm_a_out = path_sel[1] ? path_pol[0] : pwm_a_in;
    assign pwm_b_out = path_sel[0] ? path_pol[1] : pwm_b_in;
endmodule

// File: tb/pwm_deadband_gen_tb_top.sv
`timescale 1ns/1ps
module pwm_deadband_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b0;
    logic       half_cycle_en = 1'b1;
    logic [9:0] rise_dly = '0;
    logic [9:0] fall_dly = '0;
    logic [1:0] src_sel = 2'd0;
    logic [1:0] path_sel = 2'd3;
    logic [1:0] inv_sel = 2'd0;
    logic       pwm_a_in = 1'b0;
    logic       pwm_b_in = 1'b0;
    logic       pwm_a_out, pwm_b_out;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    pwm_deadband_gen dut_i (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
        .half_cycle_en(half_cycle_en), .rise_dly(rise_dly), .fall_dly(fall_dly),
        .src_sel(src_sel), .path_sel(path_sel), .inv_sel(inv_sel),
        .pwm_a_in(pwm_a_in), .pwm_b_in(pwm_b_in),
        .pwm_a_out(pwm_a_out), .pwm_b_out(pwm_b_out)
    );

    // Fields, high to low: src_sel[1:0] path_sel[1:0] inv_sel[1:0] a b
    localparam logic [7:0] VEC [16] = '{
        8'b00_00_00_1_0, 8'b00_01_10_1_0, 8'b00_10_01_0_1, 8'b00_11_10_1_0,
        8'b01_00_11_0_1, 8'b01_01_00_0_1, 8'b01_10_10_0_1, 8'b01_11_01_1_0,
        8'b10_00_01_1_1, 8'b10_01_00_1_0, 8'b10_10_11_0_1, 8'b10_11_00_0_1,
        8'b11_00_10_0_0, 8'b11_01_01_0_1, 8'b11_10_00_1_0, 8'b11_11_11_0_1
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        edges(3);
        @(negedge clk) rst_n = 1'b1;
        edges(1);
        chk("R1 out_a after reset", pwm_a_out, 1'b0);
        chk("R1 out_b after reset", pwm_b_out, 1'b0);

        // Mode table, delay 0: R2 R3 R4
        for (int i = 0; i < 16; i++) begin
            logic rs, fs, ea, eb;
            @(negedge clk);
            {src_sel, path_sel, inv_sel, pwm_a_in, pwm_b_in} = VEC[i];
            edges(3);
            rs = src_sel[0] ? pwm_b_in : pwm_a_in;
            fs = src_sel[1] ? pwm_b_in : pwm_a_in;
            ea = path_sel[1] ? (rs ^ inv_sel[0]) : pwm_a_in;
            eb = path_sel[0] ? (fs ^ inv_sel[1]) : pwm_b_in;
            chk($sformatf("R2 R3 R4 vec %0d out_a", i), pwm_a_out, ea);
            chk($sformatf("R2 R3 R4 vec %0d out_b", i), pwm_b_out, eb);
        end

        // R8: a delay of 0 gives one edge of latency
        @(negedge clk);
        src_sel = 2'd0; path_sel = 2'd3; inv_sel = 2'd0;
        pwm_a_in = 1'b0; pwm_b_in = 1'b0;
        edges(3);
        @(negedge clk) pwm_a_in = 1'b1;
        chk("R8 out_a before edge", pwm_a_out, 1'b0);
        edges(1);
        chk("R8 out_a one edge later", pwm_a_out, 1'b1);
        @(negedge clk) pwm_a_in = 1'b0;
        edges(3);

        // R5 R6 with D=5; base_tick stays 0 while half_cycle_en=1 (R9)
        @(negedge clk);
        rise_dly = 10'd5; fall_dly = 10'd5; pwm_a_in = 1'b1;
        edges(1);
        chk("R6 fall path rises at once", pwm_b_out, 1'b1);
        chk("R5 rise path held", pwm_a_out, 1'b0);
        edges(4);
        chk("R5 R9 rise path held at D edges", pwm_a_out, 1'b0);
        edges(1);
        chk("R5 R9 rise path up at D+1 edges", pwm_a_out, 1'b1);
        @(negedge clk) pwm_a_in = 1'b0;
        edges(1);
        chk("R5 rise path drops at once", pwm_a_out, 1'b0);
        chk("R6 fall path held", pwm_b_out, 1'b1);
        edges(4);
        chk("R6 fall path held at D edges", pwm_b_out, 1'b1);
        edges(1);
        chk("R6 fall path down at D+1 edges", pwm_b_out, 1'b0);

        // R7: a high pulse of D-1 clocks is swallowed
        begin
            int highs = 0;
            @(negedge clk) pwm_a_in = 1'b1;
            repeat (4) begin
                edges(1);
                if (pwm_a_out) highs++;
            end
            @(negedge clk) pwm_a_in = 1'b0;
            repeat (8) begin
                edges(1);
                if (pwm_a_out) highs++;
            end
            chk("R7 short pulse removed", highs != 0, 1'b0);
        end

        // R9: counting gated by base_tick when half_cycle_en=0
        @(negedge clk);
        half_cycle_en = 1'b0; rise_dly = 10'd2; base_tick = 1'b0; pwm_a_in = 1'b1;
        edges(20);
        chk("R9 no tick, no rise", pwm_a_out, 1'b0);
        @(negedge clk) base_tick = 1'b1;
        edges(1);
        chk("R9 one tick, still low", pwm_a_out, 1'b0);
        edges(1);
        chk("R9 two ticks, high", pwm_a_out, 1'b1);
        @(negedge clk);
        pwm_a_in = 1'b0; base_tick = 1'b0; half_cycle_en = 1'b1;
        edges(8);

        // R10: maximum delay of 1023
        @(negedge clk);
        rise_dly = 10'd1023; pwm_a_in = 1'b1;
        edges(1023);
        chk("R10 held at 1023 edges", pwm_a_out, 1'b0);
        edges(1);
        chk("R10 up at 1024 edges", pwm_a_out, 1'b1);

        // R4: complementary pair with inv_sel=2 and delay 0
        @(negedge clk);
        rise_dly = 10'd0; fall_dly = 10'd0; inv_sel = 2'b10;
        edges(2);
        chk("R4 active-high out_a", pwm_a_out, 1'b1);
        chk("R4 inverted out_b", pwm_b_out, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule